// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a pipelined signed arithmetic slice. A 27-bit pre-adder sums the D operand with either A or B. A 27 x 27 signed multiplier takes one operand from A and one from B; on the side that parameters select, the multiplier can take the pre-adder sum in place of the raw operand. A 48-bit adder then combines the product with the C operand or with the slice's own registered result. The result P wraps modulo 2^48 and is never rounded or saturated.

Every pipeline register is present or bypassed according to a depth parameter. Each register has its own clock enable and its own synchronous reset, so a designer can choose both the latency and the stall behaviour of each path. The slice has no state machine. Data moves through register stages in a fixed order: input stages, then the pre-adder stage, then the multiplier stage, then the result stage. The 2-bit operation code and the carry-in travel together through one control stage.

Top module: `preadd_mac_slice`

## Requirements
- R1: With default parameters the slice computes P = C + A*B. The multiplier operands are A[26:0] and B, and both are two's complement.
- R2: The operation code, taken after the control stage, selects the result: 00 gives C + M, 01 gives P + M (accumulate onto the registered result), 10 gives M, and 11 gives C - M. M is the product. The registered carry_in bit is added in every case.
- R3: The pre-adder computes D + X and wraps the sum to 27 bits signed. X is A[26:0] when PREADD_FROM_B = 0, and X is sign-extended B when PREADD_FROM_B = 1. When USE_PREADD = 1, this sum replaces the multiplier operand on the same side.
- R4: The number of rising edges from an input to P is the sum of the depths of the registers on its path. For raw A, the path is AREG + MREG + PREG. For raw B, it is BREG + MREG + PREG. For D, it is DREG + ADREG + MREG + PREG. For the operand selected into the pre-adder, it is that operand's depth + ADREG + MREG + PREG. For C, it is CREG + PREG. For op and carry_in, it is CTRLREG + PREG. With default depths the pre-adder path takes 4 edges.
- R5: AREG and BREG may each be 0, 1 or 2. The first stage from the input uses ce_a1 (ce_b1), and the second stage uses ce_a2 (ce_b2). When a depth is 1, the unused second enable has no effect.
- R6: While a stage's clock enable is low, that register holds its value.
- R7: A synchronous reset clears its register to zero. rst_d clears both the D register and the pre-adder register. rst_p clears P.
- R8: The operation code and carry_in share one control register, which has the enable ce_ctrl and the reset rst_ctrl. A reset value gives op 00 and carry 0.
- R9: The 48-bit result wraps on overflow, with no saturation. For example, 0x7FFF_FFFF_FFFF + 1 gives 0x8000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| a | input | 30 | Operand A, signed |
| b | input | 18 | Operand B, signed |
| d | input | 27 | Pre-adder operand D, signed |
| c | input | 48 | Adder operand C |
| op | input | 2 | Operation code |
| carry_in | input | 1 | Carry added to the result |
| ce_a1 | input | 1 | Enable, first A stage |
| ce_a2 | input | 1 | Enable, second A stage |
| ce_b1 | input | 1 | Enable, first B stage |
| ce_b2 | input | 1 | Enable, second B stage |
| ce_d | input | 1 | Enable, D stage |
| ce_ad | input | 1 | Enable, pre-adder stage |
| ce_c | input | 1 | Enable, C stage |
| ce_m | input | 1 | Enable, multiplier stage |
| ce_ctrl | input | 1 | Enable, control stage |
| ce_p | input | 1 | Enable, result stage |
| rst_a | input | 1 | Reset, A stages |
| rst_b | input | 1 | Reset, B stages |
| rst_c | input | 1 | Reset, C stage |
| rst_d | input | 1 | Reset, D and pre-adder stages |
| rst_m | input | 1 | Reset, multiplier stage |
| rst_ctrl | input | 1 | Reset, control stage |
| rst_p | input | 1 | Reset, result stage |
| p | output | 48 | Result |

## Verification
The bench runs three slices with different depths and pre-adder routing against one queue-based model. A design whose latency is wrong on any path would pair operands from different cycles and show up as a mismatch. The directed cases cover the following errors:
- A result that saturates at the top of the 48-bit range.
- A pre-adder that keeps the 28th bit of A, or that does not wrap at 27 bits.
- A single A stage wired to the second enable rather than the first.
- An rst_d that leaves the pre-adder register set.
- An op code that still acts while its control register is held in reset.

// File: rtl/slice_pkg.sv
package slice_pkg;
    localparam int A_W   = 30;
    localparam int B_W   = 18;
    localparam int D_W   = 27;
    localparam int C_W   = 48;
    localparam int P_W   = 48;
    localparam int MUL_W = 27;

    typedef enum logic [1:0] {
        OP_ADD_C    = 2'b00,
        OP_ACCUM    = 2'b01,
        OP_MUL_ONLY = 2'b10,
        OP_SUB_C    = 2'b11
    } slice_op_e;
endpackage

// File: rtl/stage_reg.sv
module stage_reg #(
    parameter int W  = 1,
    parameter int EN = 1
) (
    input  logic         clk,
    input  logic         ce,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (EN != 0) begin : g_reg
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (ce)
                    q <= din;
            end
            assign dout = q;
        end else begin : g_bypass
            logic unused_ctl;
            assign unused_ctl = &{1'b0, clk, ce, rst};
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/operand_chain.sv
module operand_chain #(
    parameter int W     = 30,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         ce1,
    input  logic         ce2,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int EN1 = (DEPTH >= 1) ? 1 : 0;
    localparam int EN2 = (DEPTH >= 2) ? 1 : 0;

    logic [W-1:0] mid;

    stage_reg #(.W(W), .EN(EN1)) u_first (
        .clk(clk), .ce(ce1), .rst(rst), .din(din), .dout(mid)
    );
    stage_reg #(.W(W), .EN(EN2)) u_second (
        .clk(clk), .ce(ce2), .rst(rst), .din(mid), .dout(dout)
    );
endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import slice_pkg::*;
(
    input  slice_op_e        op,
    input  logic [P_W-1:0]   c,
    input  logic [P_W-1:0]   m,
    input  logic [P_W-1:0]   fb,
    input  logic             cin,
    output logic [P_W-1:0]   sum
);
    logic [P_W-1:0] carry_w;
    assign carry_w = {{(P_W-1){1'b0}}, cin};

    always_comb begin
        unique case (op)
            OP_ADD_C:    sum = c + m + carry_w;
            OP_ACCUM:    sum = fb + m + carry_w;
            OP_MUL_ONLY: sum = m + carry_w;
            OP_SUB_C:    sum = c - m + carry_w;
        endcase
    end
endmodule

// File: rtl/preadd_mac_slice.sv
module preadd_mac_slice
    import slice_pkg::*;
#(
    parameter int AREG          = 1,
    parameter int BREG          = 1,
    parameter int DREG          = 1,
    parameter int ADREG         = 1,
    parameter int CREG          = 1,
    parameter int MREG          = 1,
    parameter int CTRLREG       = 1,
    parameter int PREG          = 1,
    parameter int USE_PREADD    = 0,
    parameter int PREADD_FROM_B = 0
) (
    input  logic            clk,
    input  logic [A_W-1:0]  a,
    input  logic [B_W-1:0]  b,
    input  logic [D_W-1:0]  d,
    input  logic [C_W-1:0]  c,
    input  logic [1:0]      op,
    input  logic            carry_in,
    input  logic            ce_a1,
    input  logic            ce_a2,
    input  logic            ce_b1,
    input  logic            ce_b2,
    input  logic            ce_d,
    input  logic            ce_ad,
    input  logic            ce_c,
    input  logic            ce_m,
    input  logic            ce_ctrl,
    input  logic            ce_p,
    input  logic            rst_a,
    input  logic            rst_b,
    input  logic            rst_c,
    input  logic            rst_d,
    input  logic            rst_m,
    input  logic            rst_ctrl,
    input  logic            rst_p,
    output logic [P_W-1:0]  p
);
    localparam int PROD_W  = 2 * MUL_W;
    localparam int CTRL_W  = 3;
    localparam bit PRE_ON_A = (USE_PREADD != 0) && (PREADD_FROM_B == 0);
    localparam bit PRE_ON_B = (USE_PREADD != 0) && (PREADD_FROM_B != 0);

    logic [A_W-1:0]            a_q;
    logic [B_W-1:0]            b_q;
    logic [D_W-1:0]            d_q;
    logic [C_W-1:0]            c_q;
    logic [MUL_W-1:0]          b_ext;
    logic [MUL_W-1:0]          pre_in;
    logic [MUL_W-1:0]          ad_sum;
    logic [MUL_W-1:0]          ad_q;
    logic signed [MUL_W-1:0]   mul_a;
    logic signed [MUL_W-1:0]   mul_b;
    logic signed [PROD_W-1:0]  prod;
    logic [P_W-1:0]            m_q;
    logic [CTRL_W-1:0]         ctrl_q;
    logic [1:0]                op_q;
    logic                      cin_q;
    logic [P_W-1:0]            fb;
    logic [P_W-1:0]            sum;
    logic                      unused_bits;

    // input stages
    operand_chain #(.W(A_W), .DEPTH(AREG)) u_a_chain (
        .clk(clk), .ce1(ce_a1), .ce2(ce_a2), .rst(rst_a), .din(a), .dout(a_q)
    );
    operand_chain #(.W(B_W), .DEPTH(BREG)) u_b_chain (
        .clk(clk), .ce1(ce_b1), .ce2(ce_b2), .rst(rst_b), .din(b), .dout(b_q)
    );
    stage_reg #(.W(D_W), .EN(DREG)) u_d_reg (
        .clk(clk), .ce(ce_d), .rst(rst_d), .din(d), .dout(d_q)
    );
    stage_reg #(.W(C_W), .EN(CREG)) u_c_reg (
        .clk(clk), .ce(ce_c), .rst(rst_c), .din(c), .dout(c_q)
    );
    stage_reg #(.W(CTRL_W), .EN(CTRLREG)) u_ctrl_reg (
        .clk(clk), .ce(ce_ctrl), .rst(rst_ctrl), .din({op, carry_in}), .dout(ctrl_q)
    );
    assign op_q  = ctrl_q[2:1];
    assign cin_q = ctrl_q[0];

    // pre-adder: D plus the chosen operand, wrapping at MUL_W bits
    assign b_ext  = {{(MUL_W-B_W){b_q[B_W-1]}}, b_q};
    assign pre_in = (PREADD_FROM_B != 0) ? b_ext : a_q[MUL_W-1:0];
    assign ad_sum = d_q + pre_in;

    stage_reg #(.W(MUL_W), .EN(ADREG)) u_ad_reg (
        .clk(clk), .ce(ce_ad), .rst(rst_d), .din(ad_sum), .dout(ad_q)
    );

    // multiplier
    assign mul_a = PRE_ON_A ? ad_q : a_q[MUL_W-1:0];
    assign mul_b = PRE_ON_B ? ad_q : b_ext;
    assign prod  = mul_a * mul_b;

    stage_reg #(.W(P_W), .EN(MREG)) u_m_reg (
        .clk(clk), .ce(ce_m), .rst(rst_m), .din(prod[P_W-1:0]), .dout(m_q)
    );

    // adder / accumulator
    assign fb = (PREG != 0) ? p : '0;

    slice_alu u_alu (
        .op(slice_op_e'(op_q)), .c(c_q), .m(m_q), .fb(fb), .cin(cin_q), .sum(sum)
    );

    stage_reg #(.W(P_W), .EN(PREG)) u_p_reg (
        .clk(clk), .ce(ce_p), .rst(rst_p), .din(sum), .dout(p)
    );

    assign unused_bits = &{1'b0, a_q[A_W-1:MUL_W], prod[PROD_W-1:P_W]};
endmodule

// File: rtl/slice_checker.sv
module slice_checker #(
    parameter int PREG  = 1,
    parameter int ADREG = 1
) (
    input logic        clk,
    input logic        ce_p,
    input logic        rst_p,
    input logic        rst_d,
    input logic [47:0] p,
    input logic [1:0]  op_q,
    input logic        cin_q,
    input logic [47:0] m_q,
    input logic [26:0] ad_q
);
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    generate
        if (PREG != 0) begin : g_p
            p_hold_r6: assert property (@(posedge clk) disable iff (!armed)
                (!rst_p && !ce_p) |=> $stable(p));
            p_clear_r7: assert property (@(posedge clk) disable iff (!armed)
                rst_p |=> (p == 48'd0));
            p_accum_r2: assert property (@(posedge clk) disable iff (!armed)
                (!rst_p && ce_p && op_q == 2'b01)
                |=> (p == 48'($past(p) + $past(m_q) + 48'($past(cin_q)))));
            p_mulonly_r2: assert property (@(posedge clk) disable iff (!armed)
                (!rst_p && ce_p && op_q == 2'b10)
                |=> (p == 48'($past(m_q) + 48'($past(cin_q)))));
        end
        if (ADREG != 0) begin : g_ad
            p_adclear_r7: assert property (@(posedge clk) disable iff (!armed)
                rst_d |=> (ad_q == 27'd0));
        end
    endgenerate
endmodule

bind preadd_mac_slice slice_checker #(.PREG(PREG), .ADREG(ADREG)) u_chk (
    .clk(clk), .ce_p(ce_p), .rst_p(rst_p), .rst_d(rst_d), .p(p),
    .op_q(op_q), .cin_q(cin_q), .m_q(m_q), .ad_q(ad_q)
);

// File: tb/preadd_mac_slice_test.sv
module preadd_mac_slice_test;
    logic        clk = 1'b0;
    logic [29:0] a = '0;
    logic [17:0] b = '0;
    logic [26:0] d = '0;
    logic [47:0] c = '0;
    logic [1:0]  op = '0;
    logic        carry_in = 1'b0;
    logic ce_a1 = 1, ce_a2 = 1, ce_b1 = 1, ce_b2 = 1, ce_d = 1, ce_ad = 1;
    logic ce_c = 1, ce_m = 1, ce_ctrl = 1, ce_p = 1;
    logic rst_a = 1, rst_b = 1, rst_c = 1, rst_d = 1, rst_m = 1, rst_ctrl = 1, rst_p = 1;
    logic [47:0] p0, p1, p2;

    int n_checks = 0;
    int n_fail = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;

    // uut: defaults; uut_pre: pre-adder on A, mixed depths; uut_b: pre-adder on B
    preadd_mac_slice uut (.p(p0), .*);
    preadd_mac_slice #(.AREG(2), .BREG(0), .CREG(0), .CTRLREG(0),
                       .USE_PREADD(1), .PREADD_FROM_B(0)) uut_pre (.p(p1), .*);
    preadd_mac_slice #(.DREG(0), .MREG(0), .USE_PREADD(1),
                       .PREADD_FROM_B(1)) uut_b (.p(p2), .*);

    int cf_a [3] = '{1, 2, 1};
    int cf_b [3] = '{1, 0, 1};
    int cf_d [3] = '{1, 1, 0};
    int cf_ad[3] = '{1, 1, 1};
    int cf_c [3] = '{1, 0, 1};
    int cf_m [3] = '{1, 1, 0};
    int cf_k [3] = '{1, 0, 1};
    int cf_up[3] = '{0, 1, 1};
    int cf_pb[3] = '{0, 0, 1};

    longint qa[$], qb[$], qd[$], qc[$], qop[$], qcin[$];
    longint pm[3] = '{0, 0, 0};
    localparam longint MASK48 = 64'h0000_FFFF_FFFF_FFFF;

    function automatic longint sx(longint v, int w);
        longint msk = (longint'(1) << w) - 1;
        longint h = longint'(1) << (w - 1);
        return ((v & msk) ^ h) - h;
    endfunction

    function automatic longint pre_sum(int i, int k);
        longint x = (cf_pb[i] != 0) ? sx(qb[k + cf_b[i]], 18) : sx(qa[k + cf_a[i]], 27);
        return sx(sx(qd[k + cf_d[i]], 27) + x, 27);
    endfunction

    function automatic longint a_side(int i, int k);
        if (cf_up[i] != 0 && cf_pb[i] == 0) return pre_sum(i, k + cf_ad[i]);
        return sx(qa[k + cf_a[i]], 27);
    endfunction

    function automatic longint b_side(int i, int k);
        if (cf_up[i] != 0 && cf_pb[i] != 0) return pre_sum(i, k + cf_ad[i]);
        return sx(qb[k + cf_b[i]], 18);
    endfunction

    function automatic longint calc(int i, longint pprev);
        longint m = a_side(i, cf_m[i]) * b_side(i, cf_m[i]);
        longint cc = qc[cf_c[i]];
        longint ci = qcin[cf_k[i]];
        longint r;
        case (qop[cf_k[i]])
            0: r = cc + m;
            1: r = pprev + m;
            2: r = m;
            default: r = cc - m;
        endcase
        return (r + ci) & MASK48;
    endfunction

    initial begin
        for (int k = 0; k < 8; k++) begin
            qa.push_back(0); qb.push_back(0); qd.push_back(0);
            qc.push_back(0); qop.push_back(0); qcin.push_back(0);
        end
    end

    always @(posedge clk) begin
        qa.push_front(longint'(a)); qb.push_front(longint'(b)); qd.push_front(longint'(d));
        qc.push_front(longint'(c)); qop.push_front(longint'(op)); qcin.push_front(longint'(carry_in));
        void'(qa.pop_back()); void'(qb.pop_back()); void'(qd.pop_back());
        void'(qc.pop_back()); void'(qop.pop_back()); void'(qcin.pop_back());
        for (int i = 0; i < 3; i++)
            pm[i] = rst_p ? 0 : calc(i, pm[i]);
    end

    task automatic check(string tag, logic [47:0] got, logic [47:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R1 R2 R3 R4 R9 model uut", p0, pm[0][47:0]);
            check("R1 R2 R3 R4 R9 model uut_pre", p1, pm[1][47:0]);
            check("R1 R2 R3 R4 R9 model uut_b", p2, pm[2][47:0]);
        end
    end

    task automatic set_in(logic [29:0] va, logic [17:0] vb, logic [26:0] vd,
                          logic [47:0] vc, logic [1:0] vop, logic vcin);
        a = va; b = vb; d = vd; c = vc; op = vop; carry_in = vcin;
    endtask

    task automatic settle3(string tag, logic [47:0] e0, logic [47:0] e1, logic [47:0] e2);
        repeat (7) @(negedge clk);
        check({tag, " uut"}, p0, e0);
        check({tag, " uut_pre"}, p1, e1);
        check({tag, " uut_b"}, p2, e2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] v0, v1, v2;
        repeat (6) @(negedge clk);
        rst_a = 0; rst_b = 0; rst_c = 0; rst_d = 0; rst_m = 0; rst_ctrl = 0; rst_p = 0;
        // R7 reset state
        check("R7 reset uut", p0, 48'd0);
        check("R7 reset uut_pre", p1, 48'd0);
        check("R7 reset uut_b", p2, 48'd0);
        cmp_on = 1;
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            a = 30'($urandom());
            b = 18'($urandom());
            d = 27'($urandom());
            c = 48'({$urandom(), $urandom()});
            op = 2'($urandom());
            carry_in = 1'($urandom());
            if (n % 50 == 7) begin a = 30'h2000_0000; b = 18'h20000; d = 27'h400_0000; end
        end
        @(negedge clk);
        cmp_on = 0;

        set_in(30'd1, 18'd1, 27'd0, 48'h7FFF_FFFF_FFFF, 2'b00, 1'b0);
        settle3("R9 wrap", 48'h8000_0000_0000, 48'h8000_0000_0000, 48'h8000_0000_0000);
        set_in(30'h3FFF_FFFF, 18'h3FFFF, 27'd0, 48'd5, 2'b10, 1'b0);
        settle3("R2 mul-only signs", 48'd1, 48'd1, 48'd1);
        set_in(30'd3, 18'd4, 27'd0, 48'd10, 2'b11, 1'b0);
        settle3("R2 subtract", 48'hFFFF_FFFF_FFFE, 48'hFFFF_FFFF_FFFE, 48'hFFFF_FFFF_FFFE);
        set_in(30'd0, 18'd0, 27'd0, 48'd5, 2'b00, 1'b1);
        settle3("R8 carry_in", 48'd6, 48'd6, 48'd6);

        // R2 accumulate: each edge adds 2
        set_in(30'd1, 18'd2, 27'd0, 48'd0, 2'b01, 1'b0);
        repeat (7) @(negedge clk);
        v0 = p0; v1 = p1; v2 = p2;
        @(negedge clk);
        check("R2 accumulate uut", p0 - v0, 48'd2);
        check("R2 accumulate uut_pre", p1 - v1, 48'd2);
        check("R2 accumulate uut_b", p2 - v2, 48'd2);

        set_in(30'h0800_0000, 18'd1, 27'd5, 48'd0, 2'b10, 1'b0);
        settle3("R3 A truncated to 27 bits", 48'd0, 48'd5, 48'd0);
        set_in(30'd1, 18'd1, 27'h3FF_FFFF, 48'd0, 2'b10, 1'b0);
        settle3("R3 pre-adder wraps", 48'd1, 48'hFFFF_FC00_0000, 48'hFFFF_FC00_0000);

        // R6 hold on ce_p
        set_in(30'd2, 18'd3, 27'd0, 48'd0, 2'b00, 1'b0);
        settle3("R1 steady product", 48'd6, 48'd6, 48'd6);
        ce_p = 0; c = 48'd100;
        settle3("R6 ce_p low holds", 48'd6, 48'd6, 48'd6);
        ce_p = 1;
        settle3("R6 ce_p released", 48'd106, 48'd106, 48'd106);

        // R5 per-stage A/B enables
        c = 48'd0;
        settle3("R5 baseline", 48'd6, 48'd6, 48'd6);
        ce_a2 = 0; a = 30'd4;
        settle3("R5 ce_a2 low", 48'd12, 48'd6, 48'd12);
        ce_a2 = 1; ce_a1 = 0; a = 30'd5;
        settle3("R5 ce_a1 low", 48'd12, 48'd12, 48'd12);
        ce_a1 = 1;
        settle3("R5 A enables back", 48'd15, 48'd15, 48'd15);
        ce_b1 = 0; b = 18'd7;
        settle3("R5 ce_b1 low", 48'd15, 48'd35, 48'd15);
        ce_b1 = 1;
        settle3("R5 B enable back", 48'd35, 48'd35, 48'd35);

        // R7 rst_d clears D and pre-adder registers
        set_in(30'd1, 18'd1, 27'd5, 48'd0, 2'b10, 1'b0);
        settle3("R3 pre-adder sum", 48'd1, 48'd6, 48'd6);
        rst_d = 1;
        settle3("R7 rst_d held", 48'd1, 48'd0, 48'd0);
        rst_d = 0;
        settle3("R7 rst_d released", 48'd1, 48'd6, 48'd6);

        // R8 control register reset
        set_in(30'd2, 18'd3, 27'd0, 48'd100, 2'b10, 1'b1);
        settle3("R8 mul with carry", 48'd7, 48'd7, 48'd7);
        rst_ctrl = 1;
        settle3("R8 rst_ctrl held", 48'd106, 48'd7, 48'd106);
        rst_ctrl = 0;

        rst_p = 1;
        settle3("R7 rst_p held", 48'd0, 48'd0, 48'd0);
        rst_p = 0;

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule